// File: doc/BRIEF.md
# Lockable Memory Error Logger

This block sits beside a memory read datapath and turns error events into software-visible state. The datapath reports a correctable event, an uncorrectable event, or both, together with the failing address and a small attribute word. Two sticky status bits record which kinds of error have happened. The details of the first error are captured into a log. The log then stays frozen until software has cleared both status bits. Each status bit can drive the interrupt line through its own enable bit. Correction of single-bit errors in the datapath goes on regardless of the lock. Only what is recorded is affected.

The block also shapes each read completion. A completion flagged as uncorrectable normally leaves one cycle later with the data-error output high. If its command asked for data errors to be ignored, data-error stays low and the completion signal number is replaced by a null code.

The log lock is a two-state machine. In LOG_OPEN, any error event takes the CAPTURE transition to LOG_LOCKED and loads the log. In LOG_LOCKED, the HOLD transition keeps the log as it is while any status bit stays set. The RELEASE transition returns to LOG_OPEN on the cycle in which both status bits become clear.

Top module: `mel_err_logger`

## Requirements
- R1: A correctable event (`ev_corr` high at a clock edge) sets status bit 0. The bit stays set until software clears it.
- R2: An uncorrectable event (`ev_uncorr`) sets status bit 1. The bit is sticky in the same way.
- R3: A write to register index 0 clears every status bit whose write-data bit is 1. Write-data bits of 0 leave the matching status bit unchanged.
- R4: An event that arrives in the same cycle as a clear of its status bit wins: the bit stays set.
- R5: An event that arrives while both status bits are clear loads the log. The address goes to index 2. Index 3 receives the attribute word in bits [ATTR_W-1:0] and a type bit at bit ATTR_W (1 = uncorrectable, 0 = correctable). When both kinds of event arrive together, the type is uncorrectable.
- R6: While either status bit is set, later events still set their own status bit but leave indices 2 and 3 unchanged.
- R7: Clearing only one of two set status bits does not reopen the log. Logging resumes only after both bits are clear.
- R8: Register index 1 holds the enables (bit 0 for correctable, bit 1 for uncorrectable) and reads back as written. `irq` is high exactly when a status bit and its enable are both set.
- R9: Every completion on `cpl_valid` appears one cycle later on `out_valid`. `out_data_err` is high for an uncorrectable completion without the ignore flag, and the signal number is passed through unchanged.
- R10: An uncorrectable completion with `cpl_ignore` set leaves with `out_data_err` low and `out_sig` equal to 4'hF.
- R11: The ignore flag on a completion without an uncorrectable error has no effect: no data-error, and the signal number is unchanged.
- R12: After reset, status, enables, log, `irq` and `out_valid` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_corr | input | 1 | Correctable error event |
| ev_uncorr | input | 1 | Uncorrectable error event |
| ev_addr | input | ADDR_W | Failing address |
| ev_attr | input | ATTR_W | Extra attributes of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (0 status, 1 enable, 2 log address, 3 log info) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the register at `reg_idx` (combinational) |
| irq | output | 1 | Interrupt request |
| cpl_valid | input | 1 | Read completion valid |
| cpl_uncorr | input | 1 | Completion carries an uncorrectable error |
| cpl_ignore | input | 1 | Command asked for data errors to be ignored |
| cpl_sig | input | SIG_W | Requested completion signal number |
| out_valid | output | 1 | Completion forwarded |
| out_data_err | output | 1 | Data-error flag of the forwarded completion |
| out_sig | output | SIG_W | Signal number of the forwarded completion |

## Verification
If the lock state were out of step with the status bits, the first event after a release would show at the ports. Either index 2 would keep a stale address, or a second error would overwrite the first. Both are visible on the read of the log one cycle after the event. A wrong status or enable value shows on `irq` in the same cycle. Because the completion path has one register stage, a fault there shows on the next cycle's `out_data_err` or `out_sig`.

// File: rtl/mel_pkg.sv
package mel_pkg;

    typedef enum logic {
        LOG_OPEN   = 1'b0,
        LOG_LOCKED = 1'b1
    } lock_state_t;

    localparam int unsigned REG_IDX_W   = 2;
    localparam logic [1:0]  IDX_STATUS  = 2'd0;
    localparam logic [1:0]  IDX_ENABLE  = 2'd1;
    localparam logic [1:0]  IDX_LADDR   = 2'd2;
    localparam logic [1:0]  IDX_LINFO   = 2'd3;
    localparam int unsigned NUM_KINDS   = 2;

endpackage

// File: rtl/mel_status.sv
module mel_status
    import mel_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_corr,
    input  logic                 ev_uncorr,
    input  logic [ADDR_W-1:0]    ev_addr,
    input  logic [ATTR_W-1:0]    ev_attr,
    input  logic [NUM_KINDS-1:0] clr_mask,
    output logic [NUM_KINDS-1:0] status,
    output logic [ADDR_W-1:0]    log_addr,
    output logic [ATTR_W-1:0]    log_attr,
    output logic                 log_type,
    output lock_state_t          lock_state
);

    lock_state_t          state_q, state_d;
    logic [NUM_KINDS-1:0] status_q, status_d;
    logic                 any_ev;
    logic                 capture;

    // Set has priority over clear
    always_comb begin
        any_ev   = ev_corr | ev_uncorr;
        status_d = (status_q & ~clr_mask) | {ev_uncorr, ev_corr};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOG_OPEN;
        else        state_q <= state_d;
    end

    // Transitions: CAPTURE, HOLD, RELEASE
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            LOG_OPEN: begin
                if (any_ev) begin
                    capture = 1'b1;
                    state_d = LOG_LOCKED;
                end
            end
            LOG_LOCKED: begin
                if (status_d == '0) state_d = LOG_OPEN;
            end
            default: state_d = LOG_OPEN;
        endcase
    end

    // Outputs: status bits and captured log
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            log_addr <= '0;
            log_attr <= '0;
            log_type <= 1'b0;
        end else begin
            status_q <= status_d;
            if (capture) begin
                log_addr <= ev_addr;
                log_attr <= ev_attr;
                log_type <= ev_uncorr;
            end
        end
    end

    assign status     = status_q;
    assign lock_state = state_q;

endmodule

// File: rtl/mel_regs.sv
module mel_regs
    import mel_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [NUM_KINDS-1:0] status,
    input  logic [ADDR_W-1:0]    log_addr,
    input  logic [ATTR_W-1:0]    log_attr,
    input  logic                 log_type,
    output logic [NUM_KINDS-1:0] clr_mask,
    output logic [NUM_KINDS-1:0] enable,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);

    logic [NUM_KINDS-1:0] enable_q;
    logic [NUM_KINDS-1:0] pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             enable_q <= '0;
        else if (reg_wr && reg_idx == IDX_ENABLE) enable_q <= reg_wdata[NUM_KINDS-1:0];
    end

    always_comb begin
        clr_mask = (reg_wr && reg_idx == IDX_STATUS) ? reg_wdata[NUM_KINDS-1:0] : '0;
        unique case (reg_idx)
            IDX_STATUS: reg_rdata = DATA_W'(status);
            IDX_ENABLE: reg_rdata = DATA_W'(enable_q);
            IDX_LADDR:  reg_rdata = DATA_W'(log_addr);
            IDX_LINFO:  reg_rdata = DATA_W'({log_type, log_attr});
            default:    reg_rdata = '0;
        endcase
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_pend
        assign pending[k] = status[k] & enable_q[k];
    end

    assign irq    = |pending;
    assign enable = enable_q;

endmodule

// File: rtl/mel_cpl.sv
module mel_cpl #(
    parameter int unsigned SIG_W    = 4,
    parameter logic [SIG_W-1:0] NULL_SIG = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_valid,
    input  logic             cpl_uncorr,
    input  logic             cpl_ignore,
    input  logic [SIG_W-1:0] cpl_sig,
    output logic             out_valid,
    output logic             out_data_err,
    output logic [SIG_W-1:0] out_sig
);

    logic suppress;

    always_comb suppress = cpl_uncorr & cpl_ignore;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data_err <= 1'b0;
            out_sig      <= '0;
        end else begin
            out_valid <= cpl_valid;
            if (cpl_valid) begin
                out_data_err <= cpl_uncorr & ~cpl_ignore;
                out_sig      <= suppress ? NULL_SIG : cpl_sig;
            end else begin
                out_data_err <= 1'b0;
                out_sig      <= '0;
            end
        end
    end

endmodule

// File: rtl/mel_err_logger.sv
module mel_err_logger
    import mel_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SIG_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_corr,
    input  logic                 ev_uncorr,
    input  logic [ADDR_W-1:0]    ev_addr,
    input  logic [ATTR_W-1:0]    ev_attr,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_idx,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq,
    input  logic                 cpl_valid,
    input  logic                 cpl_uncorr,
    input  logic                 cpl_ignore,
    input  logic [SIG_W-1:0]     cpl_sig,
    output logic                 out_valid,
    output logic                 out_data_err,
    output logic [SIG_W-1:0]     out_sig
);

    localparam logic [SIG_W-1:0] NULL_CODE = '1;

    logic [NUM_KINDS-1:0] status_w;
    logic [NUM_KINDS-1:0] clr_w;
    logic [NUM_KINDS-1:0] enable_w;
    logic [ADDR_W-1:0]    log_addr_w;
    logic [ATTR_W-1:0]    log_attr_w;
    logic                 log_type_w;
    lock_state_t          lock_w;

    mel_status #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_corr    (ev_corr),
        .ev_uncorr  (ev_uncorr),
        .ev_addr    (ev_addr),
        .ev_attr    (ev_attr),
        .clr_mask   (clr_w),
        .status     (status_w),
        .log_addr   (log_addr_w),
        .log_attr   (log_attr_w),
        .log_type   (log_type_w),
        .lock_state (lock_w)
    );

    mel_regs #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .status    (status_w),
        .log_addr  (log_addr_w),
        .log_attr  (log_attr_w),
        .log_type  (log_type_w),
        .clr_mask  (clr_w),
        .enable    (enable_w),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    mel_cpl #(.SIG_W(SIG_W), .NULL_SIG(NULL_CODE)) u_cpl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpl_valid    (cpl_valid),
        .cpl_uncorr   (cpl_uncorr),
        .cpl_ignore   (cpl_ignore),
        .cpl_sig      (cpl_sig),
        .out_valid    (out_valid),
        .out_data_err (out_data_err),
        .out_sig      (out_sig)
    );

endmodule

// File: rtl/mel_checker.sv
module mel_checker
    import mel_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SIG_W  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_corr,
    input logic                 ev_uncorr,
    input logic [ADDR_W-1:0]    ev_addr,
    input logic                 reg_wr,
    input logic [1:0]           reg_idx,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [NUM_KINDS-1:0] status,
    input logic [ADDR_W-1:0]    log_addr,
    input logic [ATTR_W-1:0]    log_attr,
    input logic                 log_type,
    input logic                 cpl_valid,
    input logic                 cpl_uncorr,
    input logic                 cpl_ignore,
    input logic                 out_valid,
    input logic                 out_data_err,
    input logic [SIG_W-1:0]     out_sig
);

    logic clr0, clr1;
    assign clr0 = reg_wr && (reg_idx == IDX_STATUS) && reg_wdata[0];
    assign clr1 = reg_wr && (reg_idx == IDX_STATUS) && reg_wdata[1];

    assert_corr_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_corr |=> status[0]);

    assert_uncorr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_uncorr |=> status[1]);

    assert_clear_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !ev_corr) |=> !status[0]);

    assert_clear_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr1 && !ev_uncorr) |=> !status[1]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr1 && ev_uncorr) |=> status[1]);

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0 && ev_uncorr) |=> (log_addr == $past(ev_addr) && log_type));

    assert_log_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> ($stable(log_addr) && $stable(log_attr) && $stable(log_type)));

    assert_ignore_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_uncorr && cpl_ignore) |=>
            (out_valid && !out_data_err && out_sig == '1));

    assert_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> out_valid);

endmodule

bind mel_err_logger mel_checker #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_corr      (ev_corr),
    .ev_uncorr    (ev_uncorr),
    .ev_addr      (ev_addr),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .status       (status_w),
    .log_addr     (log_addr_w),
    .log_attr     (log_attr_w),
    .log_type     (log_type_w),
    .cpl_valid    (cpl_valid),
    .cpl_uncorr   (cpl_uncorr),
    .cpl_ignore   (cpl_ignore),
    .out_valid    (out_valid),
    .out_data_err (out_data_err),
    .out_sig      (out_sig)
);

// File: tb/test_mel_err_logger.sv
`timescale 1ns/1ps
module test_mel_err_logger;

    localparam int ADDR_W = 32;
    localparam int ATTR_W = 8;
    localparam int DATA_W = 32;
    localparam int SIG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_corr = 0, ev_uncorr = 0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic [ATTR_W-1:0] ev_attr = '0;
    logic              reg_wr = 0;
    logic [1:0]        reg_idx = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;
    logic              cpl_valid = 0, cpl_uncorr = 0, cpl_ignore = 0;
    logic [SIG_W-1:0]  cpl_sig = '0;
    logic              out_valid, out_data_err;
    logic [SIG_W-1:0]  out_sig;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mel_err_logger #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W), .SIG_W(SIG_W))
    i_mel_err_logger (
        .clk(clk), .rst_n(rst_n), .ev_corr(ev_corr), .ev_uncorr(ev_uncorr),
        .ev_addr(ev_addr), .ev_attr(ev_attr), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cpl_valid(cpl_valid), .cpl_uncorr(cpl_uncorr), .cpl_ignore(cpl_ignore),
        .cpl_sig(cpl_sig), .out_valid(out_valid), .out_data_err(out_data_err),
        .out_sig(out_sig)
    );

    // {uncorr, ignore, sig[3:0], exp_err, exp_sig[3:0]}
    localparam logic [10:0] VEC [6] = '{
        {1'b0, 1'b0, 4'h3, 1'b0, 4'h3},
        {1'b1, 1'b0, 4'h5, 1'b1, 4'h5},
        {1'b1, 1'b1, 4'h5, 1'b0, 4'hF},
        {1'b0, 1'b1, 4'h7, 1'b0, 4'h7},
        {1'b1, 1'b0, 4'hA, 1'b1, 4'hA},
        {1'b1, 1'b1, 4'h0, 1'b0, 4'hF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        reg_idx = idx;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic ev(input logic c, input logic u, input logic [31:0] a, input logic [7:0] t);
        @(negedge clk);
        ev_corr = c; ev_uncorr = u; ev_addr = a; ev_attr = t;
        @(negedge clk);
        ev_corr = 0; ev_uncorr = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        rd(2'd0, 32'h0, "R12 status");
        rd(2'd1, 32'h0, "R12 enable");
        rd(2'd2, 32'h0, "R12 log addr");
        rd(2'd3, 32'h0, "R12 log info");
        chk("R12 irq", {31'b0, irq}, 32'h0);
        chk("R12 out_valid", {31'b0, out_valid}, 32'h0);

        // R9 R10 R11: completion table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cpl_valid = 1; cpl_uncorr = VEC[i][10]; cpl_ignore = VEC[i][9];
            cpl_sig = VEC[i][8:5];
            @(negedge clk);
            cpl_valid = 0;
            chk("R9 out_valid", {31'b0, out_valid}, 32'h1);
            chk("R9/R10/R11 data_err", {31'b0, out_data_err}, {31'b0, VEC[i][4]});
            chk("R9/R10/R11 sig", {28'b0, out_sig}, {28'b0, VEC[i][3:0]});
        end
        @(negedge clk);
        chk("R9 idle out_valid", {31'b0, out_valid}, 32'h0);

        // R8: enables read back
        wr(2'd1, 32'h3);
        rd(2'd1, 32'h3, "R8 enable readback");
        chk("R8 irq idle", {31'b0, irq}, 32'h0);

        // R1 R5: first correctable error
        ev(1, 0, 32'hA000_0001, 8'h11);
        rd(2'd0, 32'h1, "R1 status");
        rd(2'd2, 32'hA000_0001, "R5 log addr");
        rd(2'd3, 32'h011, "R5 log info corr");
        chk("R8 irq corr", {31'b0, irq}, 32'h1);

        // R2 R6: later uncorrectable does not overwrite
        ev(0, 1, 32'hA000_0002, 8'h22);
        rd(2'd0, 32'h3, "R2 status");
        rd(2'd2, 32'hA000_0001, "R6 log addr frozen");
        rd(2'd3, 32'h011, "R6 log info frozen");

        // R3 R7: clear one bit only, log stays locked
        wr(2'd0, 32'h1);
        rd(2'd0, 32'h2, "R3 clear bit0");
        ev(1, 0, 32'hA000_0003, 8'h33);
        rd(2'd0, 32'h3, "R6 status set while locked");
        rd(2'd2, 32'hA000_0001, "R7 still locked");
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h3, "R3 zero write no effect");

        // R3 R7 R5: clear both, logging resumes
        wr(2'd0, 32'h3);
        rd(2'd0, 32'h0, "R3 clear both");
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);
        ev(0, 1, 32'hA000_0004, 8'h44);
        rd(2'd2, 32'hA000_0004, "R7 reopened addr");
        rd(2'd3, 32'h144, "R5 log info uncorr");

        // R4: set wins over clear in the same cycle
        @(negedge clk);
        reg_wr = 1; reg_idx = 2'd0; reg_wdata = 32'h3; ev_corr = 1; ev_addr = 32'hA000_0005;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; ev_corr = 0;
        rd(2'd0, 32'h1, "R4 set wins");
        rd(2'd2, 32'hA000_0004, "R6 locked during set-wins");

        // R5: both kinds together while open -> uncorrectable type
        wr(2'd0, 32'h3);
        ev(1, 1, 32'hA000_0006, 8'h66);
        rd(2'd0, 32'h3, "R1/R2 both");
        rd(2'd3, 32'h166, "R5 both type uncorr");

        // R8: only the correctable enable, only uncorrectable pending
        wr(2'd0, 32'h1);
        wr(2'd1, 32'h1);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h2);
        chk("R8 irq enabled", {31'b0, irq}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule